// File: doc/BRIEF.md
# Temperature Threshold Alarm Filter

This block takes 10-bit temperature codes from a shared sensor front end and turns them into a filtered reading and an alarm flag for each channel. Codes use quarter-degree steps with a fixed bias: code 0 is -64 °C, so a code equals (T + 64) × 4. One channel is in service at a time. The block publishes that channel on `svc_chan`. The front end converts that channel and sends samples tagged with its number. When the block has collected the selected number of samples (1, 8 or 16), it takes their mean with a shift. It then adds a signed quarter-degree offset and limits the result: anything above 160 °C reads 0x3FF, and a sum below the bottom of the code range reads 0.

Each finished reading is stored for its channel and can be read back at any time. The reading also updates the channel's alarm. The alarm uses a programmable threshold and a hysteresis band given in whole degrees. Service then moves to the next enabled channel in ascending order and wraps round. The time between updates of any one channel therefore grows with the averaging depth and with the number of enabled channels.

Top module: `tta_filter`

## Requirements
- R1: After reset all alarms are 0, every stored reading is 0, `svc_chan` is 0 and `res_valid` is 0.
- R2: `avg_sel` picks the window: 0 means one sample (no averaging), 1 means 8 samples and 2 or 3 means 16 samples. The mean is the sum of the window divided by its size, rounded down.
- R3: The signed offset `temp_offset` (two's complement, 0.25 °C per LSB) is added to the mean before the limits are applied.
- R4: An adjusted value above 896 (160 °C) is reported as 0x3FF. A value of exactly 896 passes through unchanged.
- R5: An adjusted value below 0 is reported as 0.
- R6: A result equal to or above `alarm_thresh` sets that channel's alarm.
- R7: A set alarm clears only on a result below `alarm_thresh` − 4 × `alarm_hyst`. Results between that bound and the threshold leave the alarm as it was, and the alarm changes only when a result completes.
- R8: When a channel's window completes, or when the channel in service is disabled, service passes to the next channel with its `chan_en` bit set, searching in ascending order and wrapping. Disabled channels are skipped, and a lone enabled channel stays in service.
- R9: A sample whose tag differs from `svc_chan`, or that targets a disabled channel, is ignored. It adds nothing to the window.
- R10: The cycle after the last sample of a window is taken, `res_valid` pulses for one cycle with `res_chan` and `res_value`. `rd_value` shows the stored reading of the channel chosen by `rd_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_chan | input | CH_W | Channel tag of the sample |
| smp_code | input | 10 | Raw temperature code |
| chan_en | input | NCH | Per-channel enable |
| avg_sel | input | 2 | Averaging window select |
| temp_offset | input | 9 | Signed offset, quarter degrees |
| alarm_thresh | input | 10 | Alarm threshold code |
| alarm_hyst | input | 6 | Hysteresis, whole degrees |
| rd_sel | input | CH_W | Readback channel select |
| svc_chan | output | CH_W | Channel currently in service |
| res_valid | output | 1 | Result strobe |
| res_chan | output | CH_W | Channel of the result |
| res_value | output | 10 | Filtered, offset, limited reading |
| alarm | output | NCH | Per-channel alarm flags |
| rd_value | output | 10 | Stored reading of `rd_sel` |

## Verification
A sample counter or accumulator that is wrong shows up on the first result as an early or late `res_valid` pulse, or as a mean that is off. The scheduler pointer shows directly on `svc_chan`, so a skipped or repeated channel is visible the cycle after a window closes. An alarm register with the wrong state shows at `alarm` only when a result falls inside the hysteresis band. The stimuli therefore walk the exact band edges, one result at a time.

// File: rtl/tta_pkg.sv
package tta_pkg;
  localparam int CODE_W = 10;
  localparam int HOT_LIMIT = 896;
  localparam logic [CODE_W-1:0] SAT_CODE = 10'h3FF;

  function automatic logic [2:0] depth_shift(input logic [1:0] sel);
    case (sel)
      2'd0:    return 3'd0;
      2'd1:    return 3'd3;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [CODE_W-1:0] adjust_code(input logic [CODE_W-1:0] mean,
                                                    input logic signed [8:0] off);
    logic signed [11:0] s;
    s = $signed({2'b00, mean}) + $signed({{3{off[8]}}, off});
    if (s < 12'sd0)                return '0;
    else if (s > 12'sd896)         return SAT_CODE;
    else                           return s[CODE_W-1:0];
  endfunction

  function automatic logic alarm_next(input logic cur,
                                      input logic [CODE_W-1:0] v,
                                      input logic [CODE_W-1:0] th,
                                      input logic [5:0] hy);
    logic [CODE_W:0] low_edge;
    low_edge = {1'b0, v} + {3'b000, hy, 2'b00};
    if (v >= th)                   return 1'b1;
    else if (low_edge < {1'b0, th}) return 1'b0;
    else                           return cur;
  endfunction
endpackage

// File: rtl/tta_avg.sv
module tta_avg
  import tta_pkg::*;
#(
  parameter int ACC_W = CODE_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              flush,
  input  logic [1:0]        sel,
  input  logic [CODE_W-1:0] code,
  output logic              done,
  output logic [CODE_W-1:0] mean
);
  logic [ACC_W-1:0] acc_q, sum_nx;
  logic [3:0]       cnt_q, depth_m1;
  logic [2:0]       shift;
  logic             last;

  assign shift    = depth_shift(sel);
  assign depth_m1 = 4'((5'd1 << shift) - 5'd1);
  assign last     = cnt_q >= depth_m1;
  assign sum_nx   = acc_q + ACC_W'(code);
  assign mean     = CODE_W'(sum_nx >> shift);
  assign done     = take & last;

  always_ff @(posedge clk) begin
    if (!rst_n || flush || done) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (take) begin
      acc_q <= sum_nx;
      cnt_q <= cnt_q + 4'd1;
    end
  end
endmodule

// File: rtl/tta_rr.sv
module tta_rr #(
  parameter int NCH  = 4,
  parameter int CH_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            advance,
  input  logic [NCH-1:0]  en,
  output logic [CH_W-1:0] ptr
);
  logic [CH_W-1:0] nxt;
  logic            found;

  always_comb begin
    nxt   = ptr;
    found = 1'b0;
    for (int k = 1; k <= NCH; k++) begin
      int idx;
      idx = (int'(ptr) + k) % NCH;
      if (!found && en[idx]) begin
        nxt   = CH_W'(idx);
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr <= '0;
    else if (advance) ptr <= nxt;
  end
endmodule

// File: rtl/tta_alarm_bank.sv
module tta_alarm_bank
  import tta_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int CH_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CH_W-1:0]   wr_chan,
  input  logic [CODE_W-1:0] wr_value,
  input  logic [CODE_W-1:0] thresh,
  input  logic [5:0]        hyst,
  input  logic [CH_W-1:0]   rd_sel,
  output logic [NCH-1:0]    alarm,
  output logic [CODE_W-1:0] rd_value
);
  logic [CODE_W-1:0] val_q [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        val_q[i] <= '0;
        alarm[i] <= 1'b0;
      end else if (wr && wr_chan == CH_W'(i)) begin
        val_q[i] <= wr_value;
        alarm[i] <= alarm_next(alarm[i], wr_value, thresh, hyst);
      end
    end
  end

  assign rd_value = val_q[rd_sel];
endmodule

// File: rtl/tta_filter.sv
module tta_filter
  import tta_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [CH_W-1:0]   smp_chan,
  input  logic [CODE_W-1:0] smp_code,
  input  logic [NCH-1:0]    chan_en,
  input  logic [1:0]        avg_sel,
  input  logic signed [8:0] temp_offset,
  input  logic [CODE_W-1:0] alarm_thresh,
  input  logic [5:0]        alarm_hyst,
  input  logic [CH_W-1:0]   rd_sel,
  output logic [CH_W-1:0]   svc_chan,
  output logic              res_valid,
  output logic [CH_W-1:0]   res_chan,
  output logic [CODE_W-1:0] res_value,
  output logic [NCH-1:0]    alarm,
  output logic [CODE_W-1:0] rd_value
);
  logic              take, flush, avg_done, advance;
  logic [CODE_W-1:0] mean, adj_value;

  assign flush     = ~chan_en[svc_chan];
  assign take      = smp_valid && (smp_chan == svc_chan) && chan_en[svc_chan];
  assign advance   = avg_done | flush;
  assign adj_value = adjust_code(mean, temp_offset);

  tta_avg u_avg (
    .clk(clk), .rst_n(rst_n), .take(take), .flush(flush),
    .sel(avg_sel), .code(smp_code), .done(avg_done), .mean(mean)
  );

  tta_rr #(.NCH(NCH), .CH_W(CH_W)) u_rr (
    .clk(clk), .rst_n(rst_n), .advance(advance), .en(chan_en), .ptr(svc_chan)
  );

  tta_alarm_bank #(.NCH(NCH), .CH_W(CH_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr(avg_done), .wr_chan(svc_chan),
    .wr_value(adj_value), .thresh(alarm_thresh), .hyst(alarm_hyst),
    .rd_sel(rd_sel), .alarm(alarm), .rd_value(rd_value)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_chan  <= '0;
      res_value <= '0;
    end else begin
      res_valid <= avg_done;
      if (avg_done) begin
        res_chan  <= svc_chan;
        res_value <= adj_value;
      end
    end
  end
endmodule

// File: rtl/tta_filter_chk.sv
module tta_filter_chk #(
  parameter int NCH  = 4,
  parameter int CH_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NCH-1:0]  chan_en,
  input logic [CH_W-1:0] svc_chan,
  input logic            avg_done,
  input logic            res_valid,
  input logic [CH_W-1:0] res_chan,
  input logic [9:0]      res_value,
  input logic [NCH-1:0]  alarm,
  input logic [9:0]      alarm_thresh,
  input logic [5:0]      alarm_hyst
);
  AST_SVC_MOVES_ON_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(svc_chan) |-> $past(avg_done || !chan_en[svc_chan])); // R8
  AST_DONE_ON_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    avg_done |-> chan_en[svc_chan]); // R9
  AST_HOT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_value <= 10'd896 || res_value == 10'h3FF)); // R4
  AST_ALARM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_value >= $past(alarm_thresh)) |-> alarm[res_chan]); // R6
  AST_ALARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (({1'b0, res_value} + {3'b000, $past(alarm_hyst), 2'b00})
                   < {1'b0, $past(alarm_thresh)})) |-> !alarm[res_chan]); // R7
  AST_ALARM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable(alarm)); // R7
endmodule

bind tta_filter tta_filter_chk #(.NCH(NCH), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .svc_chan(svc_chan),
  .avg_done(avg_done), .res_valid(res_valid), .res_chan(res_chan),
  .res_value(res_value), .alarm(alarm), .alarm_thresh(alarm_thresh),
  .alarm_hyst(alarm_hyst)
);

// File: tb/tta_filter_bench.sv
module tta_filter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              smp_valid = 1'b0;
  logic [1:0]        smp_chan = '0;
  logic [9:0]        smp_code = '0;
  logic [NCH-1:0]    chan_en = 4'b0001;
  logic [1:0]        avg_sel = 2'd0;
  logic signed [8:0] temp_offset = '0;
  logic [9:0]        alarm_thresh = 10'd876;
  logic [5:0]        alarm_hyst = '0;
  logic [1:0]        rd_sel = '0;
  logic [1:0]        svc_chan;
  logic              res_valid;
  logic [1:0]        res_chan;
  logic [9:0]        res_value;
  logic [NCH-1:0]    alarm;
  logic [9:0]        rd_value;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tta_filter #(.NCH(NCH)) u_tta_filter (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_chan(smp_chan),
    .smp_code(smp_code), .chan_en(chan_en), .avg_sel(avg_sel),
    .temp_offset(temp_offset), .alarm_thresh(alarm_thresh),
    .alarm_hyst(alarm_hyst), .rd_sel(rd_sel), .svc_chan(svc_chan),
    .res_valid(res_valid), .res_chan(res_chan), .res_value(res_value),
    .alarm(alarm), .rd_value(rd_value)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expect_val(input int sum, input int n, input int off);
    int t;
    t = sum / n + off;
    if (t < 0) return 0;
    if (t > 896) return 1023;
    return t;
  endfunction

  task automatic send(input int ch, input int code);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_chan  = 2'(ch);
    smp_code  = 10'(code);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic send_svc(input int code);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_chan  = svc_chan;
    smp_code  = 10'(code);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic read_ch(input int ch, output int v);
    rd_sel = 2'(ch);
    #1;
    v = int'(rd_value);
  endtask

  task automatic t_reset();
    int v;
    chk("R1 alarm", int'(alarm), 0);
    chk("R1 svc_chan", int'(svc_chan), 0);
    chk("R1 res_valid", int'(res_valid), 0);
    for (int c = 0; c < NCH; c++) begin
      read_ch(c, v);
      chk("R1 stored reading", v, 0);
    end
  endtask

  task automatic t_single();
    int v;
    avg_sel = 2'd0;
    send_svc(400);
    chk("R10 res_valid", int'(res_valid), 1);
    chk("R10 res_chan", int'(res_chan), 0);
    chk("R2 depth1 value", int'(res_value), 400);
    read_ch(0, v);
    chk("R10 readback", v, 400);
    @(negedge clk);
    chk("R10 one-cycle pulse", int'(res_valid), 0);
  endtask

  task automatic t_depth(input logic [1:0] sel, input int n, input int base, input int step);
    int sum = 0;
    avg_sel = sel;
    for (int i = 0; i < n; i++) begin
      send_svc(base + i * step);
      sum += base + i * step;
      if (i < n - 1) chk("R2 no early result", int'(res_valid), 0);
    end
    chk("R2 window result strobe", int'(res_valid), 1);
    chk("R2 window mean", int'(res_value), expect_val(sum, n, 0));
  endtask

  task automatic t_offset_limits();
    avg_sel = 2'd0;
    temp_offset = 9'sd40;   send_svc(500);
    chk("R3 positive offset", int'(res_value), expect_val(500, 1, 40));
    temp_offset = -9'sd100; send_svc(500);
    chk("R3 negative offset", int'(res_value), expect_val(500, 1, -100));
    temp_offset = 9'sd20;   send_svc(880);
    chk("R4 hot saturate", int'(res_value), 1023);
    temp_offset = 9'sd0;    send_svc(896);
    chk("R4 exact limit passes", int'(res_value), 896);
    temp_offset = -9'sd50;  send_svc(10);
    chk("R5 cold floor", int'(res_value), 0);
    temp_offset = 9'sd0;
  endtask

  task automatic t_alarm();
    alarm_thresh = 10'd656;
    alarm_hyst   = 6'd5;
    send_svc(600); chk("R7 clear well below", int'(alarm[0]), 0);
    send_svc(655); chk("R6 below threshold", int'(alarm[0]), 0);
    send_svc(656); chk("R6 set at threshold", int'(alarm[0]), 1);
    send_svc(636); chk("R7 hold at band edge", int'(alarm[0]), 1);
    send_svc(635); chk("R7 clear below band", int'(alarm[0]), 0);
    send_svc(650); chk("R7 no set inside band", int'(alarm[0]), 0);
    alarm_thresh = 10'd876;
    alarm_hyst   = 6'd0;
  endtask

  task automatic t_round_robin();
    int v;
    chan_en = 4'b1011;
    chk("R8 start channel", int'(svc_chan), 0);
    send_svc(300); chk("R8 next after 0", int'(svc_chan), 1);
    send_svc(310); chk("R8 skip disabled 2", int'(svc_chan), 3);
    send_svc(330); chk("R8 wrap to 0", int'(svc_chan), 0);
    read_ch(1, v); chk("R10 readback ch1", v, 310);
    read_ch(3, v); chk("R10 readback ch3", v, 330);
    read_ch(2, v); chk("R9 disabled ch2 untouched", v, 0);
  endtask

  task automatic t_ignore();
    int v;
    int sum = 0;
    send(2, 999); chk("R9 disabled tag no result", int'(res_valid), 0);
    send(1, 999); chk("R9 wrong tag no result", int'(res_valid), 0);
    chk("R9 service unchanged", int'(svc_chan), 0);
    read_ch(1, v); chk("R9 ch1 reading unchanged", v, 310);
    avg_sel = 2'd1;
    for (int i = 0; i < 8; i++) begin
      send(0, 120 + i);
      sum += 120 + i;
      if (i < 7) send(3, 1000);
    end
    chk("R9 interleaved window mean", int'(res_value), expect_val(sum, 8, 0));
    chk("R9 result channel", int'(res_chan), 0);
    chk("R8 service moved on", int'(svc_chan), 1);
  endtask

  task automatic t_disable_in_service();
    chan_en = 4'b0100;
    @(negedge clk);
    @(negedge clk);
    chk("R8 disabled in-service channel left", int'(svc_chan), 2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_single();
    t_depth(2'd1, 8, 100, 1);
    t_depth(2'd2, 16, 200, 3);
    t_depth(2'd3, 16, 50, 7);
    t_offset_limits();
    t_alarm();
    t_round_robin();
    t_ignore();
    t_disable_in_service();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule